// File: doc/BRIEF.md
# Serial EEPROM transaction controller

This block is the byte-level engine of a 1 KB serial EEPROM that sits behind a two-wire slave port. A bit-level front end passes it START and STOP events, whole received bytes, and the acknowledge bit the master returns after each byte the slave sent. For every byte that needs an answer, the block returns an ACK or NACK decision. During reads it presents the byte to transmit.

The block decodes the device address byte and builds a 10-bit word pointer. It gathers up to 16 data bytes of a page write in a lane buffer. After STOP it runs a timed programming cycle that commits those bytes to an internal array. A separate checker makes the access-permission decision and feeds it back for the current pointer.

Top module: `eeprom_txn_ctrl`

## Requirements
- R1: A device byte whose upper five bits are 10101b is acknowledged when the block is idle and, for reads, when reading is permitted. Any other device byte gets a NACK. Bit 0 set means read and bit 0 clear means write. Only device, word-address and write-data bytes produce a response.
- R2: In a write header, device bits [2:1] become pointer bits [9:8] and the word-address byte becomes pointer bits [7:0]. A following read starts at that pointer.
- R3: Each accepted write-data byte advances only pointer bits [3:0]. A page write therefore wraps to the start of the same 16-byte page.
- R4: The 17th data byte of one write, and every byte after it, gets a NACK. At STOP nothing of that write is programmed.
- R5: Programming begins at STOP and holds busy_o high for PROG_CYCLES clocks. While busy, the device byte is not acknowledged.
- R6: Each transmitted read byte advances only pointer bits [6:0], so a read wraps within its 128-byte block.
- R7: A read device byte ignores its bits [2:1]. The block comes from the pointer set by the last write header.
- R8: When wp_i is high at STOP, no programming starts and the array is unchanged. The pointer set by the header still applies.
- R9: A write that carries a word address but no data byte updates the pointer and starts no programming cycle.
- R10: A master NACK (mnack_i=1) ends a read. Until the next START, received bytes get no response.
- R11: When perm_wr_ok_i is low, a data byte gets a NACK and the write is dropped. When perm_rd_ok_i is low, a read device byte gets a NACK.
- R12: After reset every array byte reads 8'hFF and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | START or repeated START seen (pulse) |
| stop_i | input | 1 | STOP seen (pulse) |
| rx_valid_i | input | 1 | A received byte is present (pulse) |
| rx_byte_i | input | 8 | Received byte |
| mack_valid_i | input | 1 | Master acknowledge bit present after a sent byte (pulse) |
| mnack_i | input | 1 | 1 when the master answered NACK |
| wp_i | input | 1 | Write protect, high blocks programming |
| perm_wr_ok_i | input | 1 | Checker allows writes at addr_o |
| perm_rd_ok_i | input | 1 | Checker allows reads at addr_o |
| ack_valid_o | output | 1 | Response to the byte of the previous cycle is valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| tx_byte_o | output | 8 | Byte to transmit at the current pointer |
| busy_o | output | 1 | Programming cycle running |
| addr_o | output | 10 | Current word pointer |

## Verification
Two events can coincide: a new device byte can arrive while a programming cycle is still counting, or a STOP can close a write whose data must not be committed. The bench starts new transactions straight after STOP, so device bytes fall inside the busy window. It expects a NACK there and compares busy_o every cycle against a countdown model that is armed only by STOPs that should program. Overflowed, write-protected, header-only and permission-denied writes each close with a STOP. In each of these cases the bench judges the outcome in two ways: busy_o must stay low, and a later read of the target bytes must return the old data.

// File: rtl/eeprom_txn_pkg.sv
package eeprom_txn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_RDATA, ST_SKIP
  } txn_st_e;
  localparam logic [4:0] DEV_ID = 5'b10101;
endpackage

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
  parameter int PAGE_W = 4,
  localparam int LANES = 1 << PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [PAGE_W-1:0]  lane_i,
  input  logic [7:0]         data_i,
  output logic [LANES-1:0]   mask_o,
  output logic [LANES*8-1:0] data_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[l]         <= 1'b0;
        data_o[l*8 +: 8]  <= 8'h00;
      end else if (clr_i) begin
        mask_o[l]         <= 1'b0;
      end else if (wr_i && lane_i == PAGE_W'(l)) begin
        mask_o[l]         <= 1'b1;
        data_o[l*8 +: 8]  <= data_i;
      end
    end
  end
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int CYCLES = 64,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end
  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int LANES = 1 << PAGE_W,
  localparam int PG_W  = ADDR_W - PAGE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [7:0]         rd_data_o,
  input  logic               wr_i,
  input  logic [PG_W-1:0]    page_i,
  input  logic [LANES-1:0]   mask_i,
  input  logic [LANES*8-1:0] data_i
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (wr_i) begin
      for (int l = 0; l < LANES; l++)
        if (mask_i[l]) mem_q[{page_i, PAGE_W'(l)}] <= data_i[l*8 +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_txn_ctrl.sv
module eeprom_txn_ctrl
  import eeprom_txn_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 4,
  parameter int BLK_OFS_W   = 7,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              mack_valid_i,
  input  logic              mnack_i,
  input  logic              wp_i,
  input  logic              perm_wr_ok_i,
  input  logic              perm_rd_ok_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic [7:0]        tx_byte_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LANES = 1 << PAGE_W;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int HI_W  = ADDR_W - 8;
  localparam int PG_W  = ADDR_W - PAGE_W;

  txn_st_e            st_q;
  logic [ADDR_W-1:0]  ptr_q;
  logic [HI_W-1:0]    hi_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               drop_q;
  logic [PG_W-1:0]    page_q;
  logic               buf_clr, buf_wr, prog_go, prog_done;
  logic [LANES-1:0]   buf_mask;
  logic [LANES*8-1:0] buf_data;
  logic               dev_hit, data_ok;

  assign dev_hit = (rx_byte_i[7:3] == DEV_ID) && !busy_o &&
                   (!rx_byte_i[0] || perm_rd_ok_i);
  assign data_ok = (cnt_q != CNT_W'(LANES)) && !drop_q && perm_wr_ok_i;
  assign buf_clr = rx_valid_i && st_q == ST_WADDR;
  assign buf_wr  = rx_valid_i && st_q == ST_WDATA && data_ok;
  assign prog_go = stop_i && !start_i && st_q == ST_WDATA &&
                   cnt_q != '0 && !drop_q && !wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ptr_q       <= '0;
      hi_q        <= '0;
      cnt_q       <= '0;
      drop_q      <= 1'b0;
      page_q      <= '0;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      ack_valid_o <= 1'b0;
      if (prog_go) page_q <= ptr_q[ADDR_W-1:PAGE_W];
      if (start_i) begin
        st_q <= ST_DEV;
      end else if (stop_i) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_DEV: if (rx_valid_i) begin
            ack_valid_o <= 1'b1;
            ack_o       <= dev_hit;
            if (!dev_hit)            st_q <= ST_SKIP;
            else if (rx_byte_i[0])   st_q <= ST_RDATA;
            else begin
              hi_q <= rx_byte_i[HI_W:1];
              st_q <= ST_WADDR;
            end
          end
          ST_WADDR: if (rx_valid_i) begin
            ack_valid_o <= 1'b1;
            ack_o       <= 1'b1;
            ptr_q       <= {hi_q, rx_byte_i};
            cnt_q       <= '0;
            drop_q      <= 1'b0;
            st_q        <= ST_WDATA;
          end
          ST_WDATA: if (rx_valid_i) begin
            ack_valid_o <= 1'b1;
            ack_o       <= data_ok;
            if (data_ok) begin
              cnt_q                <= cnt_q + 1'b1;
              ptr_q[PAGE_W-1:0]    <= ptr_q[PAGE_W-1:0] + 1'b1;
            end else begin
              drop_q <= 1'b1;
            end
          end
          ST_RDATA: if (mack_valid_i) begin
            ptr_q[BLK_OFS_W-1:0] <= ptr_q[BLK_OFS_W-1:0] + 1'b1;
            if (mnack_i) st_q <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  eeprom_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(buf_clr), .wr_i(buf_wr),
    .lane_i(ptr_q[PAGE_W-1:0]), .data_i(rx_byte_i),
    .mask_o(buf_mask), .data_o(buf_data)
  );

  eeprom_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_go), .busy_o(busy_o), .done_o(prog_done)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i, .rst_ni, .rd_addr_i(ptr_q), .rd_data_o(tx_byte_o),
    .wr_i(prog_done), .page_i(page_q), .mask_i(buf_mask), .data_i(buf_data)
  );

  assign addr_o = ptr_q;
endmodule

// File: rtl/eeprom_txn_checker.sv
module eeprom_txn_checker
  import eeprom_txn_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int BLK_OFS_W = 7,
  parameter int CNT_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              mack_valid_i,
  input logic              wp_i,
  input logic              ack_valid_o,
  input logic              ack_o,
  input logic              busy_o,
  input logic [ADDR_W-1:0] addr_o,
  input txn_st_e           st_q,
  input logic [CNT_W-1:0]  cnt_q
);
  p_busy_nack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && st_q == ST_DEV && busy_o) |=> (ack_valid_o && !ack_o));
  p_page_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && st_q == ST_WDATA) |=> $stable(addr_o[ADDR_W-1:PAGE_W]));
  p_block_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mack_valid_i && st_q == ST_RDATA) |=> $stable(addr_o[ADDR_W-1:BLK_OFS_W]));
  p_no_prog_wp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!wp_i));
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(1 << PAGE_W));
  p_ack_follows_rx_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(rx_valid_i));
endmodule

bind eeprom_txn_ctrl eeprom_txn_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BLK_OFS_W(BLK_OFS_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i, .rst_ni, .rx_valid_i, .mack_valid_i, .wp_i, .ack_valid_o, .ack_o,
  .busy_o, .addr_o, .st_q, .cnt_q
);

// File: tb/eeprom_txn_ctrl_test.sv
module eeprom_txn_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PROG = 64;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, stop_i = 0, rx_valid_i = 0, mack_valid_i = 0, mnack_i = 0;
  logic [7:0] rx_byte_i = 0;
  logic wp_i = 0, perm_wr_ok_i = 1, perm_rd_ok_i = 1;
  logic ack_valid_o, ack_o, busy_o;
  logic [7:0] tx_byte_o;
  logic [9:0] addr_o;

  int checks = 0, errors = 0;
  int ref_cnt = 0;
  bit prog_exp = 0;
  bit done = 0;
  int ref_mem [1024];
  int pend_a[$], pend_d[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_txn_ctrl #(.PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .rx_valid_i, .rx_byte_i,
    .mack_valid_i, .mnack_i, .wp_i, .perm_wr_ok_i, .perm_rd_ok_i,
    .ack_valid_o, .ack_o, .tx_byte_o, .busy_o, .addr_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference busy countdown, armed only by STOPs that should program
  always @(posedge clk) begin
    if (stop_i && prog_exp) ref_cnt <= PROG;
    else if (ref_cnt > 0)   ref_cnt <= ref_cnt - 1;
  end
  always @(negedge clk)
    if (rst_ni && !done) chk(busy_o == (ref_cnt != 0), "R5 busy", busy_o, ref_cnt != 0);

  task automatic do_start();
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
  endtask

  task automatic do_stop(input bit prog);
    prog_exp = prog;
    @(negedge clk) stop_i = 1;
    @(negedge clk) stop_i = 0;
    prog_exp = 0;
    if (prog) foreach (pend_a[i]) ref_mem[pend_a[i]] = pend_d[i];
    pend_a.delete(); pend_d.delete();
  endtask

  task automatic put(input logic [7:0] b, output bit vld, output bit ack);
    @(negedge clk) rx_valid_i = 1; rx_byte_i = b;
    @(negedge clk) rx_valid_i = 0;
    vld = ack_valid_o; ack = ack_o;
  endtask

  task automatic put_chk(input logic [7:0] b, input bit exp_ack, input string tag);
    bit v, a;
    put(b, v, a);
    chk(v && a == exp_ack, tag, {v, a}, {1'b1, exp_ack});
  endtask

  task automatic get(input bit nack, output logic [7:0] d);
    @(negedge clk) d = tx_byte_o; mack_valid_i = 1; mnack_i = nack;
    @(negedge clk) mack_valid_i = 0; mnack_i = 0;
  endtask

  task automatic wr_hdr(input int a, input string tag);
    do_start();
    put_chk(8'hA8 | 8'((a >> 8) << 1), 1, {tag, " dev"});
    put_chk(8'(a), 1, {tag, " waddr"});
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input int n, input logic [7:0] dev, input string tag);
    logic [7:0] d;
    int p;
    p = a;
    do_start();
    put_chk(dev, 1, {tag, " rdev"});
    for (int i = 0; i < n; i++) begin
      get(i == n - 1, d);
      chk(d == 8'(ref_mem[p]), tag, d, ref_mem[p]);
      p = (p & 'h380) | ((p + 1) & 'h7F);
    end
    do_stop(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: actual timeout expected completion");
    errors++;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit v, a;
    logic [7:0] d;
    for (int i = 0; i < 1024; i++) ref_mem[i] = 'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!busy_o && !ack_valid_o, "R12 reset", {busy_o, ack_valid_o}, 0);

    // R9 header-only write, R2 pointer, R12 erased contents
    wr_hdr('h005, "R9");
    do_stop(0);
    rd_chk('h005, 2, 8'hA9, "R2/R12 read");

    // R1 foreign device address
    do_start();
    put_chk(8'hA0, 0, "R1 foreign dev");
    do_stop(0);

    // R3 page wrap: 0x13E,0x13F,0x130
    wr_hdr('h13E, "R3");
    put_chk(8'h11, 1, "R3 d0"); pend_a.push_back('h13E); pend_d.push_back('h11);
    put_chk(8'h22, 1, "R3 d1"); pend_a.push_back('h13F); pend_d.push_back('h22);
    put_chk(8'h33, 1, "R3 d2"); pend_a.push_back('h130); pend_d.push_back('h33);
    do_stop(1);
    // R5 device byte while programming
    do_start();
    put_chk(8'hA8, 0, "R5 busy nack");
    do_stop(0);
    wait_idle();
    // R7: read device with B2B1=10 still reads block of pointer 0x13E
    wr_hdr('h13E, "R7");
    do_stop(0);
    rd_chk('h13E, 3, 8'hAD, "R7/R6 read");
    wr_hdr('h130, "R3b");
    do_stop(0);
    rd_chk('h130, 1, 8'hA9, "R3 wrapped byte");

    // R6 block wrap 0x17F -> 0x100
    wr_hdr('h100, "R6a");
    put_chk(8'hC3, 1, "R6 d"); pend_a.push_back('h100); pend_d.push_back('hC3);
    do_stop(1); wait_idle();
    wr_hdr('h17F, "R6b");
    put_chk(8'h5A, 1, "R6 d"); pend_a.push_back('h17F); pend_d.push_back('h5A);
    do_stop(1); wait_idle();
    wr_hdr('h17F, "R6c");
    do_stop(0);
    rd_chk('h17F, 2, 8'hA9, "R6 block wrap");

    // R4 overflow on 17th byte
    wr_hdr('h200, "R4");
    for (int i = 0; i < 16; i++) put_chk(8'(i), 1, "R4 in-page");
    put_chk(8'hEE, 0, "R4 17th nack");
    put_chk(8'hEF, 0, "R4 18th nack");
    do_stop(0);
    wr_hdr('h200, "R4r");
    do_stop(0);
    rd_chk('h200, 2, 8'hA9, "R4 nothing programmed");

    // R8 write protect: acked, no busy, pointer still set
    wp_i = 1;
    wr_hdr('h050, "R8");
    put_chk(8'h77, 1, "R8 d");
    do_stop(0);
    wp_i = 0;
    rd_chk('h050, 1, 8'hA9, "R8 unchanged");

    // R11 permissions
    wr_hdr('h060, "R11");
    perm_wr_ok_i = 0;
    put_chk(8'h44, 0, "R11 write denied");
    perm_wr_ok_i = 1;
    do_stop(0);
    perm_rd_ok_i = 0;
    do_start();
    put_chk(8'hA9, 0, "R11 read denied");
    do_stop(0);
    perm_rd_ok_i = 1;
    rd_chk('h060, 1, 8'hA9, "R11 unchanged");

    // R10 master NACK ends read, later bytes get no response
    wr_hdr('h100, "R10");
    do_stop(0);
    do_start();
    put_chk(8'hA9, 1, "R10 rdev");
    get(1, d);
    chk(d == 8'hC3, "R10 data", d, 'hC3);
    put(8'h12, v, a);
    chk(!v, "R10 no response after NACK", v, 0);
    chk(addr_o == 10'h101, "R10 pointer", addr_o, 'h101);
    do_stop(0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule